// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block decides whether one memory reference through a protected-mode style segment is allowed. On each request it takes a 64-bit descriptor, a 32-bit offset, the kind of access (read, write or execute), the access width and the current privilege level. The block rebuilds the segment base and limit from the fields that the descriptor splits across its two 32-bit halves. It scales the limit by the granularity flag and forms the linear address as base plus offset. It then runs the presence, descriptor-validity, privilege, rights and bounds checks in a fixed priority order.

One cycle after a request strobe the block returns the linear address, a grant flag and a fault code. When a reference is granted and the descriptor's accessed flag is still clear, the block also raises a write-back strobe. The strobe carries the upper descriptor half with that flag set, so the descriptor-table logic that sits next to it can store the updated copy.

Top module: `seg_access_chk`

## Requirements
- R1: One cycle after `req_valid_i` is high, `rsp_valid_o` is high and `lin_addr_o` equals base + offset modulo 2^32. The base is taken from descriptor bits 63:56 (base 31:24), bits 39:32 (base 23:16) and bits 31:16 (base 15:0). In any cycle that follows a cycle without a request, `rsp_valid_o`, `grant_o` and `wb_valid_o` are low.
- R2: The raw 20-bit limit is built from descriptor bits 51:48 (high nibble) and bits 15:0. When bit 55 (granularity) is clear, the effective limit is the raw limit. When bit 55 is set, the effective limit is raw << 12 with the low 12 bits all ones.
- R3: A segment that is not expand-down accepts an access only when offset + size_i is no greater than the effective limit. `size_i` holds the byte count minus one, so the check covers the last byte. Any other such access gets fault code 5.
- R4: A data segment (bit 43 clear) with bit 42 (expand-down) set accepts an access only when two conditions hold. The offset must exceed the effective limit. The last byte must not exceed the top offset, which is 0xFFFFFFFF when bit 54 is set and 0xFFFF when bit 54 is clear. Any other such access gets fault code 5.
- R5: A descriptor with bit 44 clear (system descriptor), or with both bit 53 and bit 54 set, gets fault code 1. This check has the highest priority.
- R6: If R5 does not apply and bit 47 (present) is clear, the fault code is 2.
- R7: The descriptor privilege level is bits 46:45. Conforming code (bit 43 and bit 42 both set) needs `cpl_i` >= that level. Every other segment needs `cpl_i` <= that level. A violation gives fault code 3, unless R5 or R6 applies first.
- R8: Access kinds are encoded as 0 read, 1 write, 2 execute and 3 reserved. The rights bit is bit 41. Code cannot be written. Code with bit 41 clear cannot be read. Data cannot be executed. Data with bit 41 clear cannot be written. The reserved kind is always refused. A refusal gives fault code 4, which ranks below the privilege fault.
- R9: The limit fault (code 5) has the lowest priority. A granted response has `grant_o` high and fault code 0, and any fault drives `grant_o` low.
- R10: `wb_valid_o` is high exactly when a response is granted and descriptor bit 40 (accessed) was clear. `wb_hi_o` then equals descriptor bits 63:32 with bit 8 set.
- R11: While `rst_ni` is low, `rsp_valid_o`, `grant_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| desc_i | input | 64 | Segment descriptor |
| offset_i | input | 32 | Logical offset |
| kind_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| size_i | input | 2 | Access bytes minus one |
| cpl_i | input | 2 | Current privilege level |
| rsp_valid_o | output | 1 | Response strobe |
| lin_addr_o | output | 32 | Linear address |
| grant_o | output | 1 | Access granted |
| fault_o | output | 3 | Fault code, 0 when granted |
| wb_valid_o | output | 1 | Descriptor write-back strobe |
| wb_hi_o | output | 32 | Updated upper descriptor half |

## Verification
The directed patterns place offsets exactly on and one past the effective limit, for both granularities and for both expand-down top offsets. This exposes off-by-one errors, missing page scaling and a wrap of the last-byte sum. Descriptors with two or three defects at once show whether the fault priority order is right, and the conforming-code cases separate the two privilege comparisons. Several hundred random descriptor, offset, kind and privilege combinations, all checked against a behavioural model, cover the field reassembly and the accessed-bit write-back.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_DESC   = 3'd1,
    FLT_NP     = 3'd2,
    FLT_PRIV   = 3'd3,
    FLT_RIGHTS = 3'd4,
    FLT_LIMIT  = 3'd5
  } fault_e;

  typedef struct packed {
    logic       db;
    logic       lng;
    logic       present;
    logic [1:0] dpl;
    logic       nonsys;
    logic       code;
    logic       ce;    // conforming (code) / expand-down (data)
    logic       rw;    // readable (code) / writable (data)
    logic       acc;
  } seg_attr_t;
endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 20,
  parameter int DESC_W = 64
) (
  input  logic [DESC_W-1:0]   desc_i,
  output logic [ADDR_W-1:0]   base_o,
  output logic [ADDR_W-1:0]   eff_lim_o,
  output seg_attr_t           attr_o,
  output logic [DESC_W/2-1:0] hi_upd_o
);
  localparam int HALF_W = DESC_W / 2;
  localparam int PAD_W  = ADDR_W - LIM_W;

  logic [HALF_W-1:0] lo, hi;
  logic [LIM_W-1:0]  raw_lim;

  assign lo = desc_i[HALF_W-1:0];
  assign hi = desc_i[DESC_W-1:HALF_W];

  assign base_o  = {hi[31:24], hi[7:0], lo[31:16]};
  assign raw_lim = {hi[19:16], lo[15:0]};

  always_comb begin
    if (hi[23]) eff_lim_o = {raw_lim, {PAD_W{1'b1}}};
    else        eff_lim_o = {{PAD_W{1'b0}}, raw_lim};
  end

  assign attr_o.db      = hi[22];
  assign attr_o.lng     = hi[21];
  assign attr_o.present = hi[15];
  assign attr_o.dpl     = hi[14:13];
  assign attr_o.nonsys  = hi[12];
  assign attr_o.code    = hi[11];
  assign attr_o.ce      = hi[10];
  assign attr_o.rw      = hi[9];
  assign attr_o.acc     = hi[8];

  assign hi_upd_o = hi | (HALF_W'(1) << 8);
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check #(
  parameter int ADDR_W = 32,
  parameter int SZ_W   = 2,
  parameter int SMALL_TOP_W = 16
) (
  input  logic [ADDR_W-1:0] off_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [ADDR_W-1:0] eff_lim_i,
  input  logic              expand_dn_i,
  input  logic              big_i,
  output logic              in_range_o
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] last, top_ofs, lim_ext;
  logic up_ok, dn_ok;

  assign last    = {1'b0, off_i} + EXT_W'(size_i);
  assign lim_ext = {1'b0, eff_lim_i};
  assign top_ofs = big_i ? {1'b0, {ADDR_W{1'b1}}} : EXT_W'({SMALL_TOP_W{1'b1}});

  assign up_ok = (last <= lim_ext);
  assign dn_ok = (off_i > eff_lim_i) && (last <= top_ofs);

  assign in_range_o = expand_dn_i ? dn_ok : up_ok;
endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
  import seg_chk_pkg::*;
(
  input  seg_attr_t  attr_i,
  input  logic [1:0] kind_i,
  input  logic [1:0] cpl_i,
  input  logic       in_range_i,
  output fault_e     fault_o
);
  logic bad_desc, priv_ok, rights_ok, conforming;

  assign bad_desc   = !attr_i.nonsys || (attr_i.lng && attr_i.db);
  assign conforming = attr_i.code && attr_i.ce;
  assign priv_ok    = conforming ? (cpl_i >= attr_i.dpl) : (cpl_i <= attr_i.dpl);

  always_comb begin
    rights_ok = 1'b0;
    unique case (kind_i)
      ACC_RD:  rights_ok = attr_i.code ? attr_i.rw : 1'b1;
      ACC_WR:  rights_ok = attr_i.code ? 1'b0 : attr_i.rw;
      ACC_EX:  rights_ok = attr_i.code;
      default: rights_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (bad_desc)               fault_o = FLT_DESC;
    else if (!attr_i.present)   fault_o = FLT_NP;
    else if (!priv_ok)          fault_o = FLT_PRIV;
    else if (!rights_ok)        fault_o = FLT_RIGHTS;
    else if (!in_range_i)       fault_o = FLT_LIMIT;
    else                        fault_o = FLT_NONE;
  end
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 20,
  parameter int DESC_W = 64,
  parameter int SZ_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [DESC_W-1:0]   desc_i,
  input  logic [ADDR_W-1:0]   offset_i,
  input  logic [1:0]          kind_i,
  input  logic [SZ_W-1:0]     size_i,
  input  logic [1:0]          cpl_i,
  output logic                rsp_valid_o,
  output logic [ADDR_W-1:0]   lin_addr_o,
  output logic                grant_o,
  output logic [2:0]          fault_o,
  output logic                wb_valid_o,
  output logic [DESC_W/2-1:0] wb_hi_o
);
  localparam int HALF_W = DESC_W / 2;

  logic [ADDR_W-1:0] base, eff_lim;
  seg_attr_t         attr;
  logic [HALF_W-1:0] hi_upd;
  logic              in_range;
  fault_e            fault_c;
  logic              grant_c;

  seg_desc_unpack #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .DESC_W(DESC_W)) u_unpack (
    .desc_i    (desc_i),
    .base_o    (base),
    .eff_lim_o (eff_lim),
    .attr_o    (attr),
    .hi_upd_o  (hi_upd)
  );

  seg_bound_check #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_bound (
    .off_i       (offset_i),
    .size_i      (size_i),
    .eff_lim_i   (eff_lim),
    .expand_dn_i (!attr.code && attr.ce),
    .big_i       (attr.db),
    .in_range_o  (in_range)
  );

  seg_rights_check u_rights (
    .attr_i     (attr),
    .kind_i     (kind_i),
    .cpl_i      (cpl_i),
    .in_range_i (in_range),
    .fault_o    (fault_c)
  );

  assign grant_c = (fault_c == FLT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      grant_o     <= 1'b0;
      wb_valid_o  <= 1'b0;
      lin_addr_o  <= '0;
      fault_o     <= '0;
      wb_hi_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      grant_o     <= req_valid_i && grant_c;
      wb_valid_o  <= req_valid_i && grant_c && !attr.acc;
      if (req_valid_i) begin
        lin_addr_o <= base + offset_i;
        fault_o    <= fault_c;
        wb_hi_o    <= hi_upd;
      end
    end
  end
endmodule

// File: rtl/seg_access_chk_sva.sv
module seg_access_chk_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [63:0] desc_i,
  input logic [31:0] offset_i,
  input logic [1:0]  kind_i,
  input logic [1:0]  size_i,
  input logic [1:0]  cpl_i,
  input logic        rsp_valid_o,
  input logic [31:0] lin_addr_o,
  input logic        grant_o,
  input logic [2:0]  fault_o,
  input logic        wb_valid_o,
  input logic [31:0] wb_hi_o
);
  logic [31:0] d_base;
  logic [32:0] d_lim, d_last;
  logic        d_ok_desc;

  assign d_base    = {desc_i[63:56], desc_i[39:32], desc_i[31:16]};
  assign d_lim     = {13'd0, desc_i[51:48], desc_i[15:0]};
  assign d_last    = {1'b0, offset_i} + {31'd0, size_i};
  assign d_ok_desc = desc_i[44] && !(desc_i[53] && desc_i[54]);

  a_r1_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i));

  a_r1_lin_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> lin_addr_o == $past(d_base + offset_i));

  a_r9_grant_vs_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (grant_o == (fault_o == 3'd0)));

  a_r5_system_desc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !desc_i[44]) |=> (fault_o == 3'd1 && !grant_o));

  a_r6_not_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && d_ok_desc && !desc_i[47]) |=> fault_o == 3'd2);

  a_r8_reserved_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && d_ok_desc && desc_i[47] && kind_i == 2'd3 && cpl_i == desc_i[46:45])
    |=> fault_o == 3'd4);

  a_r3_byte_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && d_ok_desc && desc_i[47] && !desc_i[43] && !desc_i[42] && !desc_i[55]
     && kind_i == 2'd0 && cpl_i == desc_i[46:45] && d_last > d_lim) |=> fault_o == 3'd5);

  a_r10_wb_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (grant_o && wb_hi_o[8]));

  a_r10_no_wb_when_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && desc_i[40]) |=> !wb_valid_o);
endmodule

bind seg_access_chk seg_access_chk_sva u_sva (.*);

// File: tb/seg_access_chk_bench.sv
`timescale 1ns/1ps
module seg_access_chk_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i;
  logic [63:0] desc_i;
  logic [31:0] offset_i;
  logic [1:0]  kind_i;
  logic [1:0]  size_i;
  logic [1:0]  cpl_i;
  logic        rsp_valid_o;
  logic [31:0] lin_addr_o;
  logic        grant_o;
  logic [2:0]  fault_o;
  logic        wb_valid_o;
  logic [31:0] wb_hi_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  seg_access_chk u_seg_access_chk (.*);

  function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
      input bit g, input bit db, input bit l, input bit p, input logic [1:0] dpl,
      input bit s, input logic [3:0] typ);
    logic [31:0] lo, hi;
    lo = {base[15:0], lim[15:0]};
    hi = {base[31:24], g, db, l, 1'b0, lim[19:16], p, dpl, s, typ, base[23:16]};
    return {hi, lo};
  endfunction

  function automatic int ref_fault(input logic [63:0] d, input logic [31:0] off,
      input logic [1:0] kind, input logic [1:0] sz, input logic [1:0] cpl);
    longint lim, eff, last, top;
    bit code, ce, rw, ok;
    int dpl;
    code = d[43]; ce = d[42]; rw = d[41]; dpl = int'(d[46:45]);
    lim  = longint'({d[51:48], d[15:0]});
    eff  = d[55] ? lim * 4096 + 4095 : lim;
    last = longint'(off) + longint'(sz);
    if (!d[44] || (d[53] && d[54])) return 1;
    if (!d[47]) return 2;
    if (code && ce) ok = (int'(cpl) >= dpl); else ok = (int'(cpl) <= dpl);
    if (!ok) return 3;
    case (kind)
      2'd0: ok = code ? rw : 1'b1;
      2'd1: ok = code ? 1'b0 : rw;
      2'd2: ok = code;
      default: ok = 1'b0;
    endcase
    if (!ok) return 4;
    if (!code && ce) begin
      top = d[54] ? 64'hFFFF_FFFF : 64'hFFFF;
      ok = (longint'(off) > eff) && (last <= top);
    end else ok = (last <= eff);
    if (!ok) return 5;
    return 0;
  endfunction

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] d, input logic [31:0] off, input logic [1:0] kind,
      input logic [1:0] sz, input logic [1:0] cpl, input string req);
    int ef;
    logic [31:0] ebase, elin;
    bit eg, ewb;
    ef    = ref_fault(d, off, kind, sz, cpl);
    ebase = {d[63:56], d[39:32], d[31:16]};
    elin  = ebase + off;
    eg    = (ef == 0);
    ewb   = eg && !d[40];
    @(negedge clk_i);
    req_valid_i = 1'b1; desc_i = d; offset_i = off; kind_i = kind; size_i = sz; cpl_i = cpl;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cmp(req, "rsp_valid", 64'(rsp_valid_o), 64'd1);
    cmp(req, "lin_addr",  64'(lin_addr_o), 64'(elin));
    cmp(req, "fault",     64'(fault_o), 64'(ef));
    cmp(req, "grant",     64'(grant_o), 64'(eg));
    cmp(req, "wb_valid",  64'(wb_valid_o), 64'(ewb));
    if (ewb) cmp(req, "wb_hi", 64'(wb_hi_o), 64'(d[63:32] | 32'h100));
    @(negedge clk_i);
    cmp("R1", "idle rsp_valid", 64'(rsp_valid_o), 64'd0);
    cmp("R1", "idle wb_valid",  64'(wb_valid_o), 64'd0);
  endtask

  initial begin
    logic [63:0] d;
    rst_ni = 1'b0; req_valid_i = 1'b0; desc_i = '0; offset_i = '0;
    kind_i = '0; size_i = '0; cpl_i = '0;
    repeat (3) @(negedge clk_i);
    cmp("R11", "reset rsp_valid", 64'(rsp_valid_o), 64'd0);
    cmp("R11", "reset grant",     64'(grant_o), 64'd0);
    cmp("R11", "reset wb_valid",  64'(wb_valid_o), 64'd0);
    rst_ni = 1'b1;

    // R1 / R10: plain data, accessed clear then set
    d = mk_desc(32'h1234_5678, 20'h0FFFF, 0, 1, 0, 1, 2'd0, 1, 4'b0010);
    run(d, 32'h100, 2'd0, 2'd3, 2'd0, "R1");
    run(d, 32'hFFFF_FFF0, 2'd1, 2'd0, 2'd0, "R10");
    run(d | 64'h0000_0100_0000_0000, 32'h40, 2'd0, 2'd0, 2'd0, "R10");
    // R3: last byte on and past the byte limit
    run(d, 32'hFFFC, 2'd0, 2'd3, 2'd0, "R3");
    run(d, 32'hFFFD, 2'd0, 2'd3, 2'd0, "R3");
    run(d, 32'h10000, 2'd0, 2'd0, 2'd0, "R3");
    // R2: page granularity
    d = mk_desc(32'h0040_0000, 20'h00001, 1, 1, 0, 1, 2'd0, 1, 4'b0010);
    run(d, 32'h1FFF, 2'd0, 2'd0, 2'd0, "R2");
    run(d, 32'h2000, 2'd0, 2'd0, 2'd0, "R2");
    d = mk_desc(32'h0, 20'hFFFFF, 1, 1, 0, 1, 2'd0, 1, 4'b0010);
    run(d, 32'hFFFF_FFFC, 2'd1, 2'd3, 2'd0, "R2");
    run(d, 32'hFFFF_FFFD, 2'd1, 2'd3, 2'd0, "R2");
    // R4: expand-down, big and small top
    d = mk_desc(32'h0800_0000, 20'h00FFF, 0, 1, 0, 1, 2'd0, 1, 4'b0110);
    run(d, 32'h0FFF, 2'd1, 2'd0, 2'd0, "R4");
    run(d, 32'h1000, 2'd1, 2'd0, 2'd0, "R4");
    run(d, 32'hFFFF_FFFE, 2'd0, 2'd1, 2'd0, "R4");
    run(d, 32'hFFFF_FFFE, 2'd0, 2'd3, 2'd0, "R4");
    d = mk_desc(32'h0800_0000, 20'h00FFF, 0, 0, 0, 1, 2'd0, 1, 4'b0110);
    run(d, 32'hFFFF, 2'd0, 2'd0, 2'd0, "R4");
    run(d, 32'h10000, 2'd0, 2'd0, 2'd0, "R4");
    run(d, 32'hFFFE, 2'd0, 2'd3, 2'd0, "R4");
    // R5: system descriptor outranks not-present; long with D/B
    run(mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 0, 2'd0, 0, 4'b0010), 32'h0, 2'd0, 2'd0, 2'd3, "R5");
    run(mk_desc(32'h0, 20'hFFFFF, 0, 1, 1, 1, 2'd0, 1, 4'b1010), 32'h0, 2'd2, 2'd0, 2'd0, "R5");
    // R6: not present outranks privilege
    run(mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 0, 2'd0, 1, 4'b0010), 32'h0, 2'd0, 2'd0, 2'd3, "R6");
    // R7: privilege, data / non-conforming / conforming
    run(mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b0010), 32'h0, 2'd0, 2'd0, 2'd3, "R7");
    run(mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd3, 1, 4'b0010), 32'h0, 2'd0, 2'd0, 2'd0, "R7");
    run(mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b1010), 32'h0, 2'd2, 2'd0, 2'd3, "R7");
    run(mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b1110), 32'h0, 2'd2, 2'd0, 2'd3, "R7");
    run(mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd3, 1, 4'b1110), 32'h0, 2'd2, 2'd0, 2'd0, "R7");
    // R8: rights
    d = mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b1000);
    run(d, 32'h10, 2'd0, 2'd0, 2'd0, "R8");
    run(d, 32'h10, 2'd2, 2'd0, 2'd0, "R8");
    run(d, 32'h10, 2'd1, 2'd0, 2'd0, "R8");
    d = mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b0000);
    run(d, 32'h10, 2'd1, 2'd0, 2'd0, "R8");
    run(d, 32'h10, 2'd2, 2'd0, 2'd0, "R8");
    run(d, 32'h10, 2'd0, 2'd0, 2'd0, "R8");
    run(d, 32'h10, 2'd3, 2'd0, 2'd0, "R8");
    // R9: priority among privilege, rights, limit
    d = mk_desc(32'h0, 20'h00010, 0, 1, 0, 1, 2'd0, 1, 4'b0000);
    run(d, 32'h100, 2'd1, 2'd0, 2'd3, "R9");
    run(d, 32'h100, 2'd1, 2'd0, 2'd0, "R9");
    run(d, 32'h100, 2'd0, 2'd0, 2'd0, "R9");

    // random sweep
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rb, ro;
      logic [19:0] rl;
      logic [7:0]  rm;
      rb = $urandom; ro = $urandom; rl = 20'($urandom); rm = 8'($urandom);
      if (rm[0]) ro = {12'd0, rl} + 32'($urandom_range(0, 3)) - 32'd2;
      d = mk_desc(rb, rl, rm[1], rm[2], (rm[3] & rm[4]), (rm[5] | rm[6]), 2'($urandom),
                  (rm[7] | rm[0]), 4'($urandom));
      if ($urandom_range(0, 3) == 0) d[52] = 1'b1;
      run(d, ro, 2'($urandom), 2'($urandom), 2'($urandom), "R9");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule